// File: doc/BRIEF.md
# Trace Buffer Fill Controller with Stall Handshake

This block stores 64-bit trace records, one for each record strobe sent by a remote bus-probe card running on its own clock. The strobe goes through a multi-flop synchronizer and an edge detector. Each rising edge writes the record word at the current fill position, into a memory built from eight byte-wide banks. The remote side must hold the record data stable from the strobe's rising edge until the write completes.

The fill level is compared against a high-water threshold that software can rewrite. When the level reaches the threshold, the block raises a stall request toward the probe and holds it. The threshold sits below the buffer size, so records that arrive while the traced system is still being stopped are kept. Host readout is enabled only once a synchronized stall acknowledge has come back from the probe.

During readout the host can trim records from the start and from the end of the stored run. It then reads words by index relative to the trimmed start. A clear command empties the buffer and drops the stall request, which lets the traced system resume. Records that arrive after the buffer is completely full are lost, and a sticky overflow flag records the loss.

Top module: `trace_fill_ctrl`

## Requirements
- R1: Every stored record keeps all 64 bits, spread over eight byte banks (bank b holds bits 8b+7..8b). Records are placed at consecutive indices starting at 0. With no trim, a read of index i during readout returns the i-th record stored since the last clear.
- R2: Each rising edge of the synchronized record strobe writes exactly one record, however long the strobe stays high. The strobe must be high for at least two clocks and then low for at least two clocks.
- R3: `stall_req` rises on the clock after `fill_level` first becomes greater than or equal to the high-water mark. It then stays high until a clear. With a mark of 0 it rises without any record stored.
- R4: `readout_ready` rises only after `stall_req` is high and the acknowledge has passed a two-flop synchronizer. Before that, `rd_en` yields `rd_valid` = 0.
- R5: A strobe that arrives while `fill_level` equals the depth stores nothing and leaves the stored words intact. It also sets `overflow`, and `overflow` stays set until a clear. `fill_level` never exceeds the depth.
- R6: `clear_cmd` returns `fill_level`, `stall_req`, `readout_ready`, `overflow` and both trims to 0, and capture restarts. The high-water mark is kept.
- R7: The high-water mark resets to depth minus `HEADROOM`. A `hwm_wr_en` pulse loads it from `hwm_wr_data`.
- R8: A `trim_wr_en` pulse during readout loads the start trim S and end trim E. `read_len` then becomes fill − S − E, or 0 when S + E exceeds the fill. A read of index i < `read_len` returns stored word S + i one clock later with `rd_valid` = 1. A read of an index at or beyond `read_len` gives `rd_valid` = 0.
- R9: Strobes arriving during readout store nothing and leave `fill_level` and `overflow` unchanged.
- R10: After reset, `fill_level`, `stall_req`, `readout_ready`, `overflow`, `read_len` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_strobe_async | input | 1 | Record strobe from the remote probe, asynchronous |
| rec_data | input | 64 | Record word, stable while the strobe is being captured |
| stall_ack_async | input | 1 | Stall acknowledge from the remote side, asynchronous |
| hwm_wr_en | input | 1 | Load the high-water mark |
| hwm_wr_data | input | ADDR_W+1 | New high-water mark |
| trim_wr_en | input | 1 | Load start and end trims (readout only) |
| trim_start | input | ADDR_W | Records dropped from the start |
| trim_end | input | ADDR_W | Records dropped from the end |
| clear_cmd | input | 1 | Empty the buffer and release the stall |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read index relative to the trimmed start |
| stall_req | output | 1 | Stall request toward the probe |
| readout_ready | output | 1 | Buffer handed to the host |
| fill_level | output | ADDR_W+1 | Records stored |
| read_len | output | ADDR_W+1 | Records available after trimming |
| overflow | output | 1 | Sticky lost-record flag |
| rd_data | output | 64 | Read word |
| rd_valid | output | 1 | Read word valid |

## Verification
The bench builds the block with `ADDR_W` = 4 (16 words) and `HEADROOM` = 4, so the reset high-water mark is 12. With a buffer this small, every fill position can be written and read back in each round. The bench sweeps the mark over 0, 1, 5, 12 and 16, and runs past the end of the buffer to reach overflow. Trim values that exceed the fill and index boundaries at both ends of the trimmed run are also within a few cycles.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int NUM_BANKS = 8;
  localparam int BANK_W    = 8;
  localparam int REC_W     = NUM_BANKS * BANK_W;

  typedef enum logic [1:0] {
    FILL_CAPTURE = 2'd0,
    FILL_WAIT    = 2'd1,
    FILL_READOUT = 2'd2
  } fill_state_t;
endpackage

// File: rtl/trace_sync.sv
module trace_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/trace_bank.sv
module trace_bank #(
  parameter int ADDR_W = 11,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trace_fill_ctrl.sv
module trace_fill_ctrl
  import trace_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int HEADROOM    = 1250,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_strobe_async,
  input  logic [63:0]       rec_data,
  input  logic              stall_ack_async,
  input  logic              hwm_wr_en,
  input  logic [ADDR_W:0]   hwm_wr_data,
  input  logic              trim_wr_en,
  input  logic [ADDR_W-1:0] trim_start,
  input  logic [ADDR_W-1:0] trim_end,
  input  logic              clear_cmd,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              stall_req,
  output logic              readout_ready,
  output logic [ADDR_W:0]   fill_level,
  output logic [ADDR_W:0]   read_len,
  output logic              overflow,
  output logic [63:0]       rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HWM_RESET = CNT_W'(DEPTH - HEADROOM);

  logic strobe_lvl, strobe_prev, strobe_rise, ack_lvl;
  fill_state_t state_q;
  logic [CNT_W-1:0]  fill_q, hwm_q, rlen_q, trim_sum, trim_len;
  logic [ADDR_W-1:0] trim_s_q, trim_e_q, raddr;
  logic stall_q, ready_q, ovf_q, rvalid_q;
  logic accepting, wr_en, rd_fire;

  trace_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
    .clk(clk), .rst(rst), .din(rec_strobe_async), .dout(strobe_lvl));

  trace_sync #(.STAGES(2)) u_ack_sync (
    .clk(clk), .rst(rst), .din(stall_ack_async), .dout(ack_lvl));

  assign strobe_rise = strobe_lvl & ~strobe_prev;
  assign accepting   = strobe_rise && (state_q != FILL_READOUT) && !clear_cmd;
  assign wr_en       = accepting && (fill_q < FULL_CNT);
  assign rd_fire     = rd_en && ready_q;
  assign raddr       = trim_s_q + rd_addr;

  assign trim_sum = CNT_W'(trim_s_q) + CNT_W'(trim_e_q);
  assign trim_len = (trim_sum > fill_q) ? '0 : (fill_q - trim_sum);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    trace_bank #(.ADDR_W(ADDR_W), .W(BANK_W)) u_bank (
      .clk   (clk),
      .we    (wr_en),
      .waddr (fill_q[ADDR_W-1:0]),
      .wdata (rec_data[b*BANK_W +: BANK_W]),
      .re    (rd_fire),
      .raddr (raddr),
      .rdata (rd_data[b*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_prev <= 1'b0;
      state_q     <= FILL_CAPTURE;
      fill_q      <= '0;
      hwm_q       <= HWM_RESET;
      trim_s_q    <= '0;
      trim_e_q    <= '0;
      rlen_q      <= '0;
      stall_q     <= 1'b0;
      ready_q     <= 1'b0;
      ovf_q       <= 1'b0;
      rvalid_q    <= 1'b0;
    end else begin
      strobe_prev <= strobe_lvl;
      rlen_q      <= trim_len;
      rvalid_q    <= rd_fire && ({1'b0, rd_addr} < rlen_q);
      if (hwm_wr_en) hwm_q <= hwm_wr_data;
      if (clear_cmd) begin
        state_q  <= FILL_CAPTURE;
        fill_q   <= '0;
        trim_s_q <= '0;
        trim_e_q <= '0;
        stall_q  <= 1'b0;
        ready_q  <= 1'b0;
        ovf_q    <= 1'b0;
      end else begin
        if (wr_en) fill_q <= fill_q + 1'b1;
        if (accepting && fill_q == FULL_CNT) ovf_q <= 1'b1;
        case (state_q)
          FILL_CAPTURE: if (fill_q >= hwm_q) begin
            stall_q <= 1'b1;
            state_q <= FILL_WAIT;
          end
          FILL_WAIT: if (ack_lvl) begin
            ready_q <= 1'b1;
            state_q <= FILL_READOUT;
          end
          FILL_READOUT: if (trim_wr_en) begin
            trim_s_q <= trim_start;
            trim_e_q <= trim_end;
          end
          default: state_q <= FILL_CAPTURE;
        endcase
      end
    end
  end

  assign stall_req     = stall_q;
  assign readout_ready = ready_q;
  assign fill_level    = fill_q;
  assign read_len      = rlen_q;
  assign overflow      = ovf_q;
  assign rd_valid      = rvalid_q;

  always_comb begin
    assert_fill_bound_R5: assert (rst || fill_q <= FULL_CNT);
  end

  assert_one_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (stall_q && !clear_cmd) |=> stall_q);

  assert_ready_needs_stall_R4: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> stall_q);

  assert_ready_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_q) |-> $past(ack_lvl));

  assert_full_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (fill_q == FULL_CNT && !clear_cmd) |=> (fill_q == FULL_CNT));

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
    clear_cmd |=> (fill_q == '0 && !stall_q && !ovf_q && !ready_q));

  assert_readout_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !clear_cmd) |=> $stable(fill_q));
endmodule

// File: tb/test_trace_fill_ctrl.sv
module test_trace_fill_ctrl;
  localparam int AW = 4;
  localparam int D  = 16;
  localparam int HR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rec_strobe_async = 1'b0;
  logic [63:0] rec_data = '0;
  logic stall_ack_async = 1'b0;
  logic hwm_wr_en = 1'b0;
  logic [AW:0] hwm_wr_data = '0;
  logic trim_wr_en = 1'b0;
  logic [AW-1:0] trim_start = '0, trim_end = '0;
  logic clear_cmd = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic stall_req, readout_ready, overflow, rd_valid;
  logic [AW:0] fill_level, read_len;
  logic [63:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trace_fill_ctrl #(.ADDR_W(AW), .HEADROOM(HR), .SYNC_STAGES(2)) i_trace_fill_ctrl (
    .clk(clk), .rst(rst), .rec_strobe_async(rec_strobe_async), .rec_data(rec_data),
    .stall_ack_async(stall_ack_async), .hwm_wr_en(hwm_wr_en), .hwm_wr_data(hwm_wr_data),
    .trim_wr_en(trim_wr_en), .trim_start(trim_start), .trim_end(trim_end),
    .clear_cmd(clear_cmd), .rd_en(rd_en), .rd_addr(rd_addr), .stall_req(stall_req),
    .readout_ready(readout_ready), .fill_level(fill_level), .read_len(read_len),
    .overflow(overflow), .rd_data(rd_data), .rd_valid(rd_valid));

  function automatic logic [63:0] pat(int r, int i);
    pat = {32'(r * 65536 + i * 257 + 3), ~32'(i * 3 + r * 11)} ^ {8{8'(i * 29 + r)}};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [63:0] d);
    rec_data = d; rec_strobe_async = 1'b1; cyc(3);
    rec_strobe_async = 1'b0; cyc(3);
  endtask

  task automatic do_clear();
    clear_cmd = 1'b1; cyc(1); clear_cmd = 1'b0; cyc(1);
  endtask

  task automatic set_hwm(int v);
    hwm_wr_data = (AW+1)'(v); hwm_wr_en = 1'b1; cyc(1); hwm_wr_en = 1'b0; cyc(1);
  endtask

  task automatic set_trim(int s, int e);
    trim_start = AW'(s); trim_end = AW'(e); trim_wr_en = 1'b1; cyc(1);
    trim_wr_en = 1'b0; cyc(2);
  endtask

  task automatic rd(int a, output logic [63:0] d, output logic v);
    rd_addr = AW'(a); rd_en = 1'b1; cyc(1); rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic run_round(int r, int h, int n, bit write_h);
    logic [63:0] d; logic v;
    if (write_h) set_hwm(h);
    for (int k = 1; k <= n; k++) begin
      send(pat(r, k - 1));
      check("R3 stall vs mark", 64'(stall_req), 64'(k >= h));
    end
    check("R2 one record per pulse", 64'(fill_level), 64'(n));
    check("R4 not ready before ack", 64'(readout_ready), 64'd0);
    rd(0, d, v);
    check("R4 read ignored before ack", 64'(v), 64'd0);
    stall_ack_async = 1'b1; cyc(5);
    check("R4 ready after ack", 64'(readout_ready), 64'd1);
    check("R8 untrimmed length", 64'(read_len), 64'(n));
    for (int i = 0; i < n; i++) begin
      rd(i, d, v);
      check("R1 valid", 64'(v), 64'd1);
      check("R1 data", d, pat(r, i));
    end
    if (n >= 2) begin
      set_trim(1, 1);
      check("R8 trimmed length", 64'(read_len), 64'(n - 2));
      if (n > 2) begin
        rd(0, d, v);
        check("R8 first trimmed word", d, pat(r, 1));
        rd(n - 3, d, v);
        check("R8 last trimmed word", d, pat(r, n - 2));
      end
      rd(n - 2, d, v);
      check("R8 past end invalid", 64'(v), 64'd0);
    end
    if (n == D) begin
      set_trim(10, 10);
      check("R8 oversized trim", 64'(read_len), 64'd0);
      rd(0, d, v);
      check("R8 oversized trim read", 64'(v), 64'd0);
    end
    send(pat(r, 99));
    check("R9 readout strobe ignored", 64'(fill_level), 64'(n));
    do_clear();
    check("R6 fill cleared", 64'(fill_level), 64'd0);
    check("R6 stall released", 64'(stall_req), 64'd0);
    check("R6 ready dropped", 64'(readout_ready), 64'd0);
    stall_ack_async = 1'b0; cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d; logic v;
    cyc(5); rst = 1'b0; cyc(1);
    check("R10 fill", 64'(fill_level), 64'd0);
    check("R10 stall", 64'(stall_req), 64'd0);
    check("R10 ready", 64'(readout_ready), 64'd0);
    check("R10 overflow", 64'(overflow), 64'd0);
    check("R10 read_len", 64'(read_len), 64'd0);
    check("R10 rd_valid", 64'(rd_valid), 64'd0);

    // R7: default mark is D - HR = 12
    run_round(0, D - HR, 14, 1'b0);
    run_round(1, 1, 3, 1'b1);
    run_round(2, 5, 9, 1'b1);
    run_round(3, D, D, 1'b1);

    // R5: overflow past full buffer
    set_hwm(D);
    for (int k = 0; k < D + 2; k++) begin
      send(pat(4, k));
      check("R5 overflow flag", 64'(overflow), 64'(k >= D));
    end
    check("R5 fill capped", 64'(fill_level), 64'(D));
    stall_ack_async = 1'b1; cyc(5);
    rd(D - 1, d, v);
    check("R5 last word kept", d, pat(4, D - 1));
    send(pat(4, 50));
    check("R9 overflow unchanged", 64'(overflow), 64'd1);
    do_clear();
    check("R6 overflow cleared", 64'(overflow), 64'd0);
    stall_ack_async = 1'b0; cyc(4);

    // R2: long strobe writes once
    rec_data = pat(5, 0); rec_strobe_async = 1'b1; cyc(12);
    rec_strobe_async = 1'b0; cyc(4);
    check("R2 held strobe single write", 64'(fill_level), 64'd1);
    do_clear();

    // R3: mark of 0 stalls with empty buffer; R6 keeps the mark
    set_hwm(0); cyc(2);
    check("R3 zero mark stall", 64'(stall_req), 64'd1);
    do_clear(); cyc(1);
    check("R6 mark kept after clear", 64'(stall_req), 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule